// File: doc/BRIEF.md
# Partial-Fill Instruction Cache

This block is a direct-mapped instruction cache of 1024 32-bit words, organised as 256 lines of four words, placed between the fetch stage of an in-order 32-bit processor and a word-wide memory read port. Each word has its own tag entry. The entry holds the line address, the word's offset within the line, and an invalid flag. A fetch hits only when the stored entry equals the word-aligned fetch address exactly.

On a miss, all four entries of the line are first retagged as invalid. The controller then reads the requested word and each later word of the line from memory, in ascending order. Each of these words becomes valid once its data has been written. Words that come before the requested offset stay invalid. Two kinds of fetch bypass the cache without allocating a line: fetches from high addresses, and every fetch while the cache is disabled.

A control input enables the cache and selects maintenance modes. In those modes, a processor store rewrites the tags and valid flags of a line instead of going to memory.

Top module: `pfill_icache`

## Requirements
- R1: After reset every word entry is invalid, so no fetch can hit. With no fetch pending, `fetch_ready_o` and `mem_req_valid_o` are low.
- R2: A cached fetch whose entry equals `{addr[31:2],2'b00}`, with the invalid flag (entry bit 1) clear, raises `fetch_ready_o` in the same cycle. It returns the stored word and makes no memory request.
- R3: A cached miss at word offset k (address bits [3:2]) issues one memory read for each offset from k to 3, in ascending order, each at `{line,offset,2'b00}`. The memory used here accepts at once and answers in the next cycle. With that memory, the word arrives and `fetch_ready_o` rises 2*(4-k)+1 clock edges after the request.
- R4: After a miss refill, the words of the line below the requested offset remain invalid, and a later fetch of such a word misses.
- R5: A fetch whose line maps to the same index as a cached line but has a different line address misses. Its refill replaces the earlier line.
- R6: A fetch is uncached when its address is 0xA0000000 or higher, or when control bit 11 is 0. An uncached fetch issues one read at the word-aligned address and is ready 3 edges later. It changes no tag entry.
- R7: A store with control bit 11 set and tag-test bit 2 set retags the four words of line `addr[11:4]` with line address `addr[31:4]`. The valid flags come from `(data << 8*addr[1:0])[3:0]`, where bit i set marks word i valid. Neither memory nor the data array is touched.
- R8: A store with control bit 11 set and invalidate bit 1 or lock bit 0 set retags the addressed line with all four words invalid.
- R9: A store with control bit 11 set and bits 2..0 clear writes `data << 8*addr[1:0]` into data word `addr[11:2]`. A store with bit 11 clear changes nothing in the cache.
- R10: The memory request holds `mem_req_valid_o` and `mem_req_addr_o` steady until accepted. At most one read is outstanding at any time.
- R11: A store presented while the cache is idle is taken in that cycle, and `fetch_ready_o` stays low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 32 | Control word: bit 11 enable, bit 2 tag test, bit 1 invalidate, bit 0 lock |
| fetch_req_i | input | 1 | Fetch request, held until ready |
| fetch_addr_i | input | 32 | Fetch address |
| fetch_ready_o | output | 1 | Instruction valid this cycle |
| fetch_instr_o | output | 32 | Fetched instruction |
| store_i | input | 1 | Processor store aimed at the cache |
| store_addr_i | input | 32 | Store address |
| store_data_i | input | 32 | Store data |
| mem_req_valid_o | output | 1 | Memory word read request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | 32 | Memory word address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | 32 | Memory read data |

## Verification
The hardest state to reach from the ports is a line whose valid flags form an arbitrary pattern while its data words still hold earlier contents. Only a tag-test store followed by fetches can expose that state. The stimulus first fills a line, then overwrites single data words with cache-enabled stores at several byte offsets. It then retags the line under a foreign line address with a sparse valid mask, so hits return the old data and the holes miss. A reference tag and data array in the bench predicts the latency, the data and the memory traffic of every fetch. A memory stall on the first read of a refill checks that the request is held.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_BYP_REQ,
    ST_BYP_WAIT,
    ST_BYP_DONE
  } ic_state_e;

  // Align a byte-addressed store value to its byte lane.
  function automatic logic [31:0] lane_shift(input logic [31:0] d, input logic [1:0] b);
    return d << {b, 3'b000};
  endfunction

  // Build a tag entry: line address, word offset, invalid flag, zero.
  function automatic logic [31:0] make_tag(input logic [27:0] line, input logic [1:0] off,
                                           input logic inval);
    return {line, off, inval, 1'b0};
  endfunction

  function automatic logic [31:0] word_align(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/icache_tags.sv
module icache_tags
  import icache_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [31:0]        rd_tag,
  input  logic               line_we,
  input  logic [IDX_W-3:0]   line_sel,
  input  logic [27:0]        line_base,
  input  logic [3:0]         line_inval,
  input  logic               clr_we,
  input  logic [IDX_W-1:0]   clr_idx
);
  localparam int WORDS = 1 << IDX_W;

  logic [31:0] tag_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) tag_q[i] <= make_tag(28'd0, 2'd0, 1'b1);
    end else begin
      if (line_we) begin
        for (int w = 0; w < 4; w++)
          tag_q[{line_sel, 2'(w)}] <= make_tag(line_base, 2'(w), line_inval[w]);
      end
      if (clr_we) tag_q[clr_idx][1] <= 1'b0;
    end
  end

  assign rd_tag = tag_q[rd_idx];

endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);
  localparam int WORDS = 1 << IDX_W;

  logic [31:0] data_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) data_q[widx] <= wdata;
  end

  assign rd_data = data_q[rd_idx];

endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
  import icache_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_req,
  input  logic [31:0] fetch_addr,
  input  logic        uncached,
  input  logic        hit,
  input  logic        store_req,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output ic_state_e   state_o,
  output logic        mem_req_valid,
  output logic [31:0] mem_req_addr,
  output logic        miss_start,
  output logic        fill_we,
  output logic [31:0] fill_addr,
  output logic [31:0] byp_data
);
  ic_state_e   state_q;
  logic [27:0] line_q;
  logic [1:0]  off_q;
  logic [31:0] baddr_q;
  logic [31:0] bdata_q;
  logic        idle_free;
  logic        byp_start;

  assign idle_free  = (state_q == ST_IDLE) && !store_req;
  assign miss_start = idle_free && fetch_req && !uncached && !hit;
  assign byp_start  = idle_free && fetch_req && uncached;
  assign fill_addr  = {line_q, off_q, 2'b00};
  assign fill_we    = (state_q == ST_FILL_WAIT) && mem_rsp_valid;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = fill_addr;
    if (state_q == ST_FILL_REQ) begin
      mem_req_valid = 1'b1;
    end else if (state_q == ST_BYP_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = baddr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      off_q   <= '0;
      baddr_q <= '0;
      bdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (miss_start) begin
            line_q  <= fetch_addr[31:4];
            off_q   <= fetch_addr[3:2];
            state_q <= ST_FILL_REQ;
          end else if (byp_start) begin
            baddr_q <= word_align(fetch_addr);
            state_q <= ST_BYP_REQ;
          end
        end
        ST_FILL_REQ:  if (mem_req_ready) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: begin
          if (mem_rsp_valid) begin
            if (off_q == 2'd3) begin
              state_q <= ST_IDLE;
            end else begin
              off_q   <= off_q + 2'd1;
              state_q <= ST_FILL_REQ;
            end
          end
        end
        ST_BYP_REQ:   if (mem_req_ready) state_q <= ST_BYP_WAIT;
        ST_BYP_WAIT: begin
          if (mem_rsp_valid) begin
            bdata_q <= mem_rsp_data;
            state_q <= ST_BYP_DONE;
          end
        end
        ST_BYP_DONE:  state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign byp_data = bdata_q;

endmodule

// File: rtl/pfill_icache.sv
module pfill_icache
  import icache_pkg::*;
#(
  parameter int          IDX_W         = 10,
  parameter logic [31:0] UNCACHED_BASE = 32'hA000_0000,
  parameter int          EN_BIT        = 11,
  parameter int          TEST_BIT      = 2,
  parameter int          INVAL_BIT     = 1,
  parameter int          LOCK_BIT      = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ctrl_i,
  input  logic        fetch_req_i,
  input  logic [31:0] fetch_addr_i,
  output logic        fetch_ready_o,
  output logic [31:0] fetch_instr_o,
  input  logic        store_i,
  input  logic [31:0] store_addr_i,
  input  logic [31:0] store_data_i,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [31:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i
);
  localparam logic [31:0] MODE_MASK = (32'd1 << TEST_BIT) | (32'd1 << INVAL_BIT)
                                    | (32'd1 << LOCK_BIT);
  localparam int LINE_W = IDX_W - 2;

  ic_state_e   state;
  logic        cache_en;
  logic        uncached;
  logic        lookup_hit;
  logic [31:0] tag_rd;
  logic [31:0] data_rd;
  logic        miss_start;
  logic        fill_we;
  logic [31:0] fill_addr;
  logic [31:0] byp_data;
  logic        store_take;
  logic        mode_on;
  logic        test_store;
  logic        data_store;
  logic        fill_busy;
  logic        byp_busy;
  logic        byp_done;
  logic [31:0] store_lane;
  logic [3:0]  store_valid;
  logic        tag_line_we;
  logic [LINE_W-1:0] tag_line_sel;
  logic [27:0] tag_line_base;
  logic [3:0]  tag_line_inval;
  logic        dat_we;
  logic [IDX_W-1:0] dat_idx;
  logic [31:0] dat_wdata;

  assign cache_en   = ctrl_i[EN_BIT];
  assign uncached   = !cache_en || (fetch_addr_i >= UNCACHED_BASE);
  assign lookup_hit = (tag_rd == word_align(fetch_addr_i));

  assign fill_busy  = (state == ST_FILL_REQ) || (state == ST_FILL_WAIT);
  assign byp_busy   = (state == ST_BYP_REQ) || (state == ST_BYP_WAIT);
  assign byp_done   = (state == ST_BYP_DONE);

  // Store path: only taken while the controller is idle.
  assign store_take  = store_i && (state == ST_IDLE) && cache_en;
  assign mode_on     = |(ctrl_i & MODE_MASK);
  assign test_store  = store_take && mode_on;
  assign data_store  = store_take && !mode_on;
  assign store_lane  = lane_shift(store_data_i, store_addr_i[1:0]);
  assign store_valid = ctrl_i[TEST_BIT] ? store_lane[3:0] : 4'h0;

  assign tag_line_we    = miss_start || test_store;
  assign tag_line_sel   = test_store ? store_addr_i[IDX_W+1:4] : fetch_addr_i[IDX_W+1:4];
  assign tag_line_base  = test_store ? store_addr_i[31:4] : fetch_addr_i[31:4];
  assign tag_line_inval = test_store ? ~store_valid : 4'hF;

  assign dat_we    = fill_we || data_store;
  assign dat_idx   = fill_we ? fill_addr[IDX_W+1:2] : store_addr_i[IDX_W+1:2];
  assign dat_wdata = fill_we ? mem_rsp_data_i : store_lane;

  icache_tags #(.IDX_W(IDX_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (fetch_addr_i[IDX_W+1:2]),
    .rd_tag     (tag_rd),
    .line_we    (tag_line_we),
    .line_sel   (tag_line_sel),
    .line_base  (tag_line_base),
    .line_inval (tag_line_inval),
    .clr_we     (fill_we),
    .clr_idx    (fill_addr[IDX_W+1:2])
  );

  icache_data #(.IDX_W(IDX_W)) u_data (
    .clk     (clk),
    .we      (dat_we),
    .widx    (dat_idx),
    .wdata   (dat_wdata),
    .rd_idx  (fetch_addr_i[IDX_W+1:2]),
    .rd_data (data_rd)
  );

  icache_fill_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_req     (fetch_req_i),
    .fetch_addr    (fetch_addr_i),
    .uncached      (uncached),
    .hit           (lookup_hit),
    .store_req     (store_i),
    .mem_req_ready (mem_req_ready_i),
    .mem_rsp_valid (mem_rsp_valid_i),
    .mem_rsp_data  (mem_rsp_data_i),
    .state_o       (state),
    .mem_req_valid (mem_req_valid_o),
    .mem_req_addr  (mem_req_addr_o),
    .miss_start    (miss_start),
    .fill_we       (fill_we),
    .fill_addr     (fill_addr),
    .byp_data      (byp_data)
  );

  assign fetch_ready_o = fetch_req_i &&
                         (byp_done || ((state == ST_IDLE) && !store_i && !uncached && lookup_hit));
  assign fetch_instr_o = byp_done ? byp_data : data_rd;

endmodule

// File: rtl/pfill_icache_chk.sv
module pfill_icache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_ready_o,
  input logic        store_i,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic [31:0] mem_req_addr_o,
  input logic        mem_rsp_valid_i,
  input logic        miss_start,
  input logic        fill_busy,
  input logic        byp_busy,
  input logic        byp_done,
  input logic        lookup_hit,
  input logic        tag_line_we
);
  logic        hs;
  logic [1:0]  outst_q;
  logic        have_prev_q;
  logic [31:0] prev_addr_q;

  assign hs = mem_req_valid_o && mem_req_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q     <= '0;
      have_prev_q <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      outst_q <= outst_q + {1'b0, hs} - {1'b0, mem_rsp_valid_i};
      if (miss_start) have_prev_q <= 1'b0;
      else if (hs && fill_busy) begin
        have_prev_q <= 1'b1;
        prev_addr_q <= mem_req_addr_o;
      end
    end
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> outst_q == 2'd0);

  a_r10_rsp_matches_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid_i |-> outst_q == 2'd1);

  a_r3_ascending_words: assert property (@(posedge clk) disable iff (!rst_n)
    hs && fill_busy && have_prev_q |-> mem_req_addr_o == prev_addr_q + 32'd4);

  a_r6_bypass_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    byp_busy |-> !tag_line_we);

  a_r2_ready_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready_o && !byp_done |-> lookup_hit);

  a_r11_store_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    store_i && !byp_done |-> !fetch_ready_o);

endmodule

bind pfill_icache pfill_icache_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fetch_ready_o   (fetch_ready_o),
  .store_i         (store_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .miss_start      (miss_start),
  .fill_busy       (fill_busy),
  .byp_busy        (byp_busy),
  .byp_done        (byp_done),
  .lookup_hit      (lookup_hit),
  .tag_line_we     (tag_line_we)
);

// File: tb/pfill_icache_bench.sv
module pfill_icache_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ctrl;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_ready;
  logic [31:0] fetch_instr;
  logic        store_i;
  logic [31:0] store_addr;
  logic [31:0] store_data;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  pfill_icache u_pfill_icache (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
    .fetch_ready_o(fetch_ready), .fetch_instr_o(fetch_instr),
    .store_i(store_i), .store_addr_i(store_addr), .store_data_i(store_data),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Memory model: accepts when not stalled, answers next cycle.
  int          stall_left = 0;
  int          req_cnt = 0;
  int          req_base = 0;
  logic [31:0] first_addr = '0;
  logic [31:0] last_addr = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h0101};
  endfunction

  assign mem_req_ready = (stall_left == 0);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_word(mem_req_addr);
      if (req_cnt == req_base) first_addr <= mem_req_addr;
      last_addr <= mem_req_addr;
      req_cnt <= req_cnt + 1;
    end else if (mem_req_valid && stall_left > 0) begin
      stall_left <= stall_left - 1;
    end
  end

  // Reference model of tags and data.
  logic [31:0] ref_tag [1024];
  logic [31:0] ref_dat [1024];

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, input int stall, input string req);
    logic [31:0] wa;
    logic [9:0]  idx;
    int          elat;
    int          enreq;
    logic [31:0] edat;
    int          lat;
    int          n;
    bit          unc;
    wa  = {a[31:2], 2'b00};
    idx = a[11:2];
    unc = !ctrl[11] || (a >= 32'hA000_0000);
    if (unc) begin
      elat = 3 + stall; edat = mem_word(wa); enreq = 1;
    end else if (ref_tag[idx] == wa) begin
      elat = 0; edat = ref_dat[idx]; enreq = 0;
    end else begin
      n = 4 - int'(a[3:2]);
      elat = 2 * n + 1 + stall; edat = mem_word(wa); enreq = n;
      for (int i = 0; i < 4; i++)
        ref_tag[{a[11:4], 2'(i)}] = {a[31:4], 2'(i), (i < int'(a[3:2])), 1'b0};
      for (int i = int'(a[3:2]); i < 4; i++)
        ref_dat[{a[11:4], 2'(i)}] = mem_word({a[31:4], 2'(i), 2'b00});
    end
    @(negedge clk);
    req_base   = req_cnt;
    stall_left = (enreq > 0) ? stall : 0;
    fetch_req  = 1'b1;
    fetch_addr = a;
    lat = 0;
    #1;
    while (!fetch_ready && lat < 60) begin
      @(negedge clk);
      #1;
      lat++;
    end
    chk(req, $sformatf("latency @%h", a), lat, elat);
    chk(req, $sformatf("instr @%h", a), fetch_instr, edat);
    fetch_req = 1'b0;
    chk(req, $sformatf("mem reads @%h", a), req_cnt - req_base, enreq);
    if (enreq > 0) begin
      chk(req, "first read addr", first_addr, wa);
      chk(req, "last read addr", last_addr, unc ? wa : {a[31:4], 4'hC});
    end
  endtask

  task automatic do_store(input logic [31:0] c, input logic [31:0] a, input logic [31:0] d);
    logic [31:0] sh;
    logic [3:0]  vb;
    sh = d << (8 * int'(a[1:0]));
    if (c[11]) begin
      if (c[2] || c[1] || c[0]) begin
        vb = c[2] ? sh[3:0] : 4'h0;
        for (int i = 0; i < 4; i++)
          ref_tag[{a[11:4], 2'(i)}] = {a[31:4], 2'(i), ~vb[i], 1'b0};
      end else begin
        ref_dat[a[11:2]] = sh;
      end
    end
    @(negedge clk);
    ctrl = c; store_i = 1'b1; store_addr = a; store_data = d;
    @(negedge clk);
    store_i = 1'b0;
  endtask

  // Table: {enable, address}
  localparam int NV = 13;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 32'h0000_0100},  // R1 R3: first fetch misses, fill from offset 0
    {1'b1, 32'h0000_0104},  // R2 hit
    {1'b1, 32'h0000_010C},  // R2 hit
    {1'b1, 32'h0000_0208},  // R3 fill from offset 2
    {1'b1, 32'h0000_0200},  // R4 earlier word invalid
    {1'b1, 32'h0000_1100},  // R5 alias misses
    {1'b1, 32'h0000_0100},  // R5 evicted line misses
    {1'b1, 32'hA000_0104},  // R6 high address bypass
    {1'b0, 32'h0000_0104},  // R6 disabled cache bypass
    {1'b1, 32'h0000_0104},  // R6 no allocation: still a hit
    {1'b1, 32'h0000_030C},  // R3 fill single word at offset 3
    {1'b1, 32'h0000_0300},  // R4 miss below fill point
    {1'b1, 32'h0000_0304}   // R2 hit after full fill
  };

  initial begin
    rst_n = 1'b0; ctrl = 32'h800; fetch_req = 1'b0; fetch_addr = '0;
    store_i = 1'b0; store_addr = '0; store_data = '0;
    for (int i = 0; i < 1024; i++) begin ref_tag[i] = 32'h2; ref_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "ready after reset", {31'd0, fetch_ready}, 32'd0);
    chk("R1", "mem valid after reset", {31'd0, mem_req_valid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      ctrl = VEC[v][32] ? 32'h800 : 32'h0;
      do_fetch(VEC[v][31:0], 0, $sformatf("table%0d", v));
    end
    ctrl = 32'h800;

    // R9 data stores with byte offsets, and ignored when disabled
    do_store(32'h800, 32'h0000_0108, 32'h1234_5678);
    do_fetch(32'h0000_0108, 0, "R9");
    do_store(32'h800, 32'h0000_010A, 32'h0000_00AB);
    do_fetch(32'h0000_0108, 0, "R9");
    do_store(32'h000, 32'h0000_0104, 32'hDEAD_BEEF);
    ctrl = 32'h800;
    do_fetch(32'h0000_0104, 0, "R9");

    // R7 tag-test stores
    do_store(32'h804, 32'h0000_5100, 32'h0000_0005);
    ctrl = 32'h800;
    do_fetch(32'h0000_5100, 0, "R7");
    do_fetch(32'h0000_5108, 0, "R7");
    do_fetch(32'h0000_5104, 0, "R7");
    do_store(32'h804, 32'h0000_5101, 32'h0000_000F);
    ctrl = 32'h800;
    do_fetch(32'h0000_510C, 0, "R7");

    // R8 invalidate and lock modes
    do_store(32'h802, 32'h0000_0300, 32'hFFFF_FFFF);
    ctrl = 32'h800;
    do_fetch(32'h0000_0308, 0, "R8");
    do_store(32'h801, 32'h0000_0208, 32'hFFFF_FFFF);
    ctrl = 32'h800;
    do_fetch(32'h0000_0200, 0, "R8");

    // R10 stalled memory on first read
    do_fetch(32'h0000_0700, 3, "R10");

    // R11 store and fetch in the same cycle
    @(negedge clk);
    store_i = 1'b1; store_addr = 32'h0000_0600; store_data = 32'h0BAD_F00D;
    ref_dat[10'h180] = 32'h0BAD_F00D;
    fetch_req = 1'b1; fetch_addr = 32'h0000_0704;
    #1;
    chk("R11", "ready during store", {31'd0, fetch_ready}, 32'd0);
    @(negedge clk);
    store_i = 1'b0;
    #1;
    chk("R11", "ready after store", {31'd0, fetch_ready}, 32'd1);
    chk("R11", "instr after store", fetch_instr, mem_word(32'h0000_0704));
    fetch_req = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule